// File: doc/BRIEF.md
# Vector branch condition evaluator

This block settles the outcome of a single vectorised conditional branch. The caller presents a vector length, a loop counter, one condition bit per element, a predicate mask and a handful of mode controls, then pulses a start strobe. The block walks the elements one per clock, lowest index first. It folds the per-element results into one taken or not-taken decision, using either an every-element rule or an any-element rule. It stops at the element that settles the outcome.

When the scan ends, the block raises a one-cycle done pulse. At the same moment it presents the decision, a vector length that may have been cut short at the deciding element, and a loop counter that may have been reduced by the whole vector length. In vertical-first operation only one element, the one at index 0, is judged. Two combinations are undefined configurations and are reported on a dedicated flag. Decoding which condition bit feeds each element and computing the branch target are left to the surrounding logic.

Top module: `vec_branch_eval`

## Requirements
- R1: `mode_i[1]` selects counter mode and `mode_i[0]` selects VL-truncate mode. Both bits may be set together. With `mode_i[1]` clear, the counter leaves unchanged. With `mode_i[0]` clear, the vector length leaves unchanged.
- R2: With `all_i` set, the branch is taken only when no examined element fails. All-skipped elements and an empty active set therefore count as taken.
- R3: With `all_i` clear, the branch is taken as soon as one examined element passes. If none passes, it is not taken.
- R4: An element whose `pred_i` bit is 0 is skipped while `zero_i` is 0. While `zero_i` is 1, such an element counts as a non-passing test, which decides the outcome under the every-element rule. An element with `pred_i` bit 1 passes exactly when its `cond_i` bit is 1.
- R5: Scanning stops at the deciding element: the first failure under the every-element rule, or the first pass under the any-element rule. If no element decides, scanning runs to the last element. For a nonzero VL, `done_o` rises k+1 cycles after the start cycle, where k is the number of elements examined.
- R6: In VL-truncate mode, the vector length is cut only when a deciding element at index d exists and `taken_o` equals `trunc_on_taken_i`. The new length is d+1 when `trunc_incl_i` is 1, and d when it is 0. In every other case the vector length stays as it was.
- R7: In counter mode with `vert_first_i` clear and VL nonzero, `ctr_o` equals `ctr_i` minus VL, modulo 2^CTR_W.
- R8: With `vert_first_i` set, only element 0 is judged, whatever the VL, so `done_o` rises 2 cycles after start.
- R9: `undef_o` equals `vert_first_i AND (all_i OR mode_i[1])` for the request. In counter mode with `vert_first_i` set and VL nonzero, `ctr_o` equals `ctr_i` minus 1, modulo 2^CTR_W.
- R10: A VL of zero gives not taken, VL 0 and an unchanged counter, and `done_o` rises 1 cycle after start.
- R11: A start strobe during a scan is ignored. `taken_o`, `vl_o`, `ctr_o` and `undef_o` change only in a cycle in which `done_o` is high.
- R12: After reset, `done_o`, `taken_o`, `vl_o`, `ctr_o` and `undef_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin evaluation; sampled only while idle |
| all_i | input | 1 | 1: every-element rule; 0: any-element rule |
| zero_i | input | 1 | 1: masked-out elements count as non-passing |
| trunc_on_taken_i | input | 1 | VL is cut when the outcome equals this bit |
| trunc_incl_i | input | 1 | 1: truncated VL includes the deciding element |
| mode_i | input | 2 | [1] counter mode, [0] VL-truncate mode |
| vert_first_i | input | 1 | Vertical-first operation: judge element 0 only |
| vl_i | input | $clog2(MAX_VL+1) | Vector length, 0..MAX_VL |
| ctr_i | input | CTR_W | Loop counter before the branch |
| cond_i | input | MAX_VL | Per-element condition results, bit i is element i |
| pred_i | input | MAX_VL | Predicate mask, bit i is element i |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| taken_o | output | 1 | Branch decision |
| vl_o | output | $clog2(MAX_VL+1) | Resulting vector length |
| ctr_o | output | CTR_W | Resulting loop counter |
| undef_o | output | 1 | Request used an undefined configuration |

## Verification
The checker relies on two assumptions about the inputs: `vl_i` never exceeds MAX_VL, and a start strobe is judged against the request captured at the last accepted start. The stimulus enforces both. Every length it drives lies between 0 and the configured maximum. It issues each new request only at the falling edge on which the previous done pulse is seen, and the deliberately overlapping strobe arrives only during a scan, where it must be dropped. The bench sweeps every condition and predicate pattern for each length and rule on a four-element build, together with a full vertical-first sweep whose upper condition bits vary so that their irrelevance shows at the ports.

// File: rtl/vbe_pkg.sv
// Package: shared types and helpers for the vector branch evaluator.
// Assumes nothing beyond being compiled before the modules that import it.
package vbe_pkg;

    // Scan controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } vbe_state_e;

    // Per-request mode controls captured at start
    typedef struct packed {
        logic all_rule;        // every-element rule when set
        logic zero_mask;       // masked elements count as non-passing
        logic trunc_on_taken;  // outcome value that triggers truncation
        logic include_decider; // truncated length keeps the deciding element
        logic ctr_mode;        // subtract length from counter
        logic vlset_mode;      // allow vector length truncation
        logic vert_first;      // single-element operation
    } vbe_cfg_t;

    // Decide whether one element ends the scan
    function automatic logic vbe_elem_stop(
        input logic all_rule,
        input logic zero_mask,
        input logic pred_bit,
        input logic cond_bit
    );
        if (all_rule)
            return pred_bit ? ~cond_bit : zero_mask;
        else
            return pred_bit & cond_bit;
    endfunction

    // Flag the configurations that have no defined meaning
    function automatic logic vbe_cfg_undef(input vbe_cfg_t cfg);
        return cfg.vert_first & (cfg.all_rule | cfg.ctr_mode);
    endfunction

endpackage

// File: rtl/vbe_elem_pick.sv
// Module: vbe_elem_pick
// Selects the condition and predicate bits of the element at idx using a
// one-hot decode. Assumes idx < N; out-of-range indices select nothing.
module vbe_elem_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     cond_vec,
    input  logic [N-1:0]     pred_vec,
    input  logic [IDX_W-1:0] idx,
    output logic             cond_bit,
    output logic             pred_bit
);

    logic [N-1:0] hit;

    // One decoder slice per element position
    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = (idx == IDX_W'(g));
    end

    // AND-OR reduce the selected element
    always_comb begin
        cond_bit = |(hit & cond_vec);
        pred_bit = |(hit & pred_vec);
    end

endmodule

// File: rtl/vbe_step_judge.sv
// Module: vbe_step_judge
// Judges the current element and reports whether it decides the branch
// and whether it is the final element of the scan window.
// Assumes limit >= 1 whenever the result is used.
module vbe_step_judge
    import vbe_pkg::*;
#(
    parameter int VL_W  = 5,
    parameter int IDX_W = 4
) (
    input  logic             all_rule,
    input  logic             zero_mask,
    input  logic             cond_bit,
    input  logic             pred_bit,
    input  logic [IDX_W-1:0] idx,
    input  logic [VL_W-1:0]  limit,
    output logic             stop,
    output logic             last
);

    // Element verdict and end-of-window detection
    always_comb begin
        stop = vbe_elem_stop(all_rule, zero_mask, pred_bit, cond_bit);
        last = (VL_W'(idx) == (limit - VL_W'(1)));
    end

endmodule

// File: rtl/vbe_result_calc.sv
// Module: vbe_result_calc
// Forms the decision, the resulting vector length and the resulting counter
// from the scan outcome. Assumes a nonzero vector length; the zero-length
// case is handled by the caller.
module vbe_result_calc #(
    parameter int VL_W  = 5,
    parameter int CTR_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             all_rule,
    input  logic             trunc_on_taken,
    input  logic             include_decider,
    input  logic             ctr_mode,
    input  logic             vlset_mode,
    input  logic             vert_first,
    input  logic [VL_W-1:0]  vl,
    input  logic [CTR_W-1:0] ctr,
    input  logic             stopped,
    input  logic [IDX_W-1:0] idx,
    output logic             taken,
    output logic [VL_W-1:0]  vl_new,
    output logic [CTR_W-1:0] ctr_new
);

    logic [VL_W-1:0] dec_pos;
    logic            trunc;

    // Decision: an early stop inverts the rule's default outcome
    always_comb begin
        taken = stopped ? ~all_rule : all_rule;
    end

    // Vector length: cut at the deciding element when the outcome matches
    always_comb begin
        dec_pos = VL_W'(idx);
        trunc   = vlset_mode & stopped & (taken == trunc_on_taken);
        if (trunc)
            vl_new = include_decider ? (dec_pos + VL_W'(1)) : dec_pos;
        else
            vl_new = vl;
    end

    // Counter: whole-length subtract, or single decrement in vertical-first
    always_comb begin
        if (!ctr_mode)
            ctr_new = ctr;
        else if (vert_first)
            ctr_new = ctr - CTR_W'(1);
        else
            ctr_new = ctr - CTR_W'(vl);
    end

endmodule

// File: rtl/vec_branch_eval.sv
// Module: vec_branch_eval (top)
// Evaluates one vectorised conditional branch: captures the request on
// start, scans one element per cycle until the outcome is decided or the
// window ends, then pulses done with decision, length and counter.
// Assumes vl_i <= MAX_VL. Starts seen while scanning are dropped.
module vec_branch_eval
    import vbe_pkg::*;
#(
    parameter int MAX_VL = 16,
    parameter int CTR_W  = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              all_i,
    input  logic              zero_i,
    input  logic              trunc_on_taken_i,
    input  logic              trunc_incl_i,
    input  logic [1:0]        mode_i,
    input  logic              vert_first_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [CTR_W-1:0]  ctr_i,
    input  logic [MAX_VL-1:0] cond_i,
    input  logic [MAX_VL-1:0] pred_i,
    output logic              done_o,
    output logic              taken_o,
    output logic [VL_W-1:0]   vl_o,
    output logic [CTR_W-1:0]  ctr_o,
    output logic              undef_o
);

    vbe_state_e        state_q;
    vbe_cfg_t          cfg_in;
    vbe_cfg_t          cfg_q;
    logic [VL_W-1:0]   vl_q;
    logic [CTR_W-1:0]  ctr_q;
    logic [MAX_VL-1:0] cond_q;
    logic [MAX_VL-1:0] pred_q;
    logic [IDX_W-1:0]  idx_q;
    logic [VL_W-1:0]   limit;
    logic              cond_bit;
    logic              pred_bit;
    logic              stop;
    logic              last;
    logic              accept;
    logic              finish;
    logic              res_taken;
    logic [VL_W-1:0]   res_vl;
    logic [CTR_W-1:0]  res_ctr;
    logic              busy_w;

    // Pack the mode inputs into the request record
    always_comb begin
        cfg_in.all_rule        = all_i;
        cfg_in.zero_mask       = zero_i;
        cfg_in.trunc_on_taken  = trunc_on_taken_i;
        cfg_in.include_decider = trunc_incl_i;
        cfg_in.ctr_mode        = mode_i[1];
        cfg_in.vlset_mode      = mode_i[0];
        cfg_in.vert_first      = vert_first_i;
    end

    // Handshake and window derivation
    always_comb begin
        busy_w = (state_q == ST_SCAN);
        accept = (state_q == ST_IDLE) && start_i;
        limit  = cfg_q.vert_first ? VL_W'(1) : vl_q;
        finish = busy_w && (stop || last);
    end

    vbe_elem_pick #(
        .N     (MAX_VL),
        .IDX_W (IDX_W)
    ) u_pick (
        .cond_vec (cond_q),
        .pred_vec (pred_q),
        .idx      (idx_q),
        .cond_bit (cond_bit),
        .pred_bit (pred_bit)
    );

    vbe_step_judge #(
        .VL_W  (VL_W),
        .IDX_W (IDX_W)
    ) u_judge (
        .all_rule  (cfg_q.all_rule),
        .zero_mask (cfg_q.zero_mask),
        .cond_bit  (cond_bit),
        .pred_bit  (pred_bit),
        .idx       (idx_q),
        .limit     (limit),
        .stop      (stop),
        .last      (last)
    );

    vbe_result_calc #(
        .VL_W  (VL_W),
        .CTR_W (CTR_W),
        .IDX_W (IDX_W)
    ) u_calc (
        .all_rule        (cfg_q.all_rule),
        .trunc_on_taken  (cfg_q.trunc_on_taken),
        .include_decider (cfg_q.include_decider),
        .ctr_mode        (cfg_q.ctr_mode),
        .vlset_mode      (cfg_q.vlset_mode),
        .vert_first      (cfg_q.vert_first),
        .vl              (vl_q),
        .ctr             (ctr_q),
        .stopped         (stop),
        .idx             (idx_q),
        .taken           (res_taken),
        .vl_new          (res_vl),
        .ctr_new         (res_ctr)
    );

    // Capture the request when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            vl_q   <= '0;
            ctr_q  <= '0;
            cond_q <= '0;
            pred_q <= '0;
        end else if (accept) begin
            cfg_q  <= cfg_in;
            vl_q   <= vl_i;
            ctr_q  <= ctr_i;
            cond_q <= cond_i;
            pred_q <= pred_i;
        end
    end

    // Scan state and element index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (accept && (vl_i != '0))
                        state_q <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (finish)
                        state_q <= ST_IDLE;
                    else
                        idx_q <= idx_q + IDX_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            taken_o <= 1'b0;
            vl_o    <= '0;
            ctr_o   <= '0;
            undef_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept && (vl_i == '0)) begin
                done_o  <= 1'b1;
                taken_o <= 1'b0;
                vl_o    <= '0;
                ctr_o   <= ctr_i;
                undef_o <= vbe_cfg_undef(cfg_in);
            end else if (finish) begin
                done_o  <= 1'b1;
                taken_o <= res_taken;
                vl_o    <= res_vl;
                ctr_o   <= res_ctr;
                undef_o <= vbe_cfg_undef(cfg_q);
            end
        end
    end

endmodule

// File: rtl/vbe_checker.sv
// Module: vbe_checker
// Property checks on the evaluator's ports. Keeps its own copy of the
// request taken at each accepted start. Assumes vl_i <= MAX_VL.
module vbe_checker #(
    parameter int MAX_VL = 16,
    parameter int CTR_W  = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int CNT_W = $clog2(MAX_VL + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             all_i,
    input logic [1:0]       mode_i,
    input logic             vert_first_i,
    input logic [VL_W-1:0]  vl_i,
    input logic [CTR_W-1:0] ctr_i,
    input logic             busy,
    input logic             done_o,
    input logic             taken_o,
    input logic [VL_W-1:0]  vl_o,
    input logic [CTR_W-1:0] ctr_o,
    input logic             undef_o
);

    logic             c_all;
    logic             c_ctrm;
    logic             c_vlset;
    logic             c_vf;
    logic [VL_W-1:0]  c_vl;
    logic [CTR_W-1:0] c_ctr;
    logic [CNT_W-1:0] run_cnt;

    // Shadow copy of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_all   <= 1'b0;
            c_ctrm  <= 1'b0;
            c_vlset <= 1'b0;
            c_vf    <= 1'b0;
            c_vl    <= '0;
            c_ctr   <= '0;
        end else if (start_i && !busy) begin
            c_all   <= all_i;
            c_ctrm  <= mode_i[1];
            c_vlset <= mode_i[0];
            c_vf    <= vert_first_i;
            c_vl    <= vl_i;
            c_ctr   <= ctr_i;
        end
    end

    // Count consecutive scanning cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (busy)
            run_cnt <= run_cnt + CNT_W'(1);
        else
            run_cnt <= '0;
    end

    // R10
    vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && vl_i == '0) |=>
            (done_o && !taken_o && vl_o == '0 && ctr_o == $past(ctr_i)));

    // R9
    undef_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (undef_o == (c_vf & (c_all | c_ctrm))));

    // R9
    ctr_vf_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_ctrm && c_vf && c_vl != '0) |-> (ctr_o == c_ctr - CTR_W'(1)));

    // R7
    ctr_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_ctrm && !c_vf && c_vl != '0) |-> (ctr_o == c_ctr - CTR_W'(c_vl)));

    // R1
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (!c_ctrm || c_vl == '0)) |-> (ctr_o == c_ctr));

    // R1
    vl_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !c_vlset) |-> (vl_o == c_vl));

    // R6
    vl_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (vl_o <= c_vl));

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(taken_o) && $stable(vl_o) && $stable(ctr_o) && $stable(undef_o)));

    // R5
    scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CNT_W'(MAX_VL)));

endmodule

bind vec_branch_eval vbe_checker #(
    .MAX_VL (MAX_VL),
    .CTR_W  (CTR_W)
) u_vbe_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .all_i        (all_i),
    .mode_i       (mode_i),
    .vert_first_i (vert_first_i),
    .vl_i         (vl_i),
    .ctr_i        (ctr_i),
    .busy         (busy_w),
    .done_o       (done_o),
    .taken_o      (taken_o),
    .vl_o         (vl_o),
    .ctr_o        (ctr_o),
    .undef_o      (undef_o)
);

// File: tb/vec_branch_eval_bench.sv
// Bench: sweeps a four-element, 8-bit-counter build of vec_branch_eval over
// every condition and predicate pattern, comparing against values computed
// from the requirements.
module vec_branch_eval_bench;

    localparam int NV      = 4;
    localparam int CW      = 8;
    localparam int VW      = $clog2(NV + 1);
    localparam int CLK_PER = 10;
    localparam int WD_MAX  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          all_i = 1'b0;
    logic          zero_i = 1'b0;
    logic          tot_i = 1'b0;
    logic          incl_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          vf_i = 1'b0;
    logic [VW-1:0] vl_i = '0;
    logic [CW-1:0] ctr_i = '0;
    logic [NV-1:0] cond_i = '0;
    logic [NV-1:0] pred_i = '0;
    logic          done_o;
    logic          taken_o;
    logic [VW-1:0] vl_o;
    logic [CW-1:0] ctr_o;
    logic          undef_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    vec_branch_eval #(
        .MAX_VL (NV),
        .CTR_W  (CW)
    ) u_vec_branch_eval (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .all_i            (all_i),
        .zero_i           (zero_i),
        .trunc_on_taken_i (tot_i),
        .trunc_incl_i     (incl_i),
        .mode_i           (mode_i),
        .vert_first_i     (vf_i),
        .vl_i             (vl_i),
        .ctr_i            (ctr_i),
        .cond_i           (cond_i),
        .pred_i           (pred_i),
        .done_o           (done_o),
        .taken_o          (taken_o),
        .vl_o             (vl_o),
        .ctr_o            (ctr_o),
        .undef_o          (undef_o)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_MAX) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WD_MAX);
            finish_run();
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Issue one request at a falling edge and wait for done; returns latency
    task automatic issue(input logic a, z, t, i, input logic [1:0] m, input logic vf,
                         input int vl, input int ctr, input int cond, input int pred,
                         output int lat);
        all_i  = a;    zero_i = z;   tot_i = t;  incl_i = i;
        mode_i = m;    vf_i   = vf;  vl_i = VW'(vl);
        ctr_i  = CW'(ctr);  cond_i = NV'(cond);  pred_i = NV'(pred);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Expected values taken from the requirements
    task automatic run_case(input logic a, z, t, i, input logic [1:0] m, input logic vf,
                            input int vl, input int ctr, input int cond, input int pred);
        int lat, lim, d, e_lat, e_vl, e_ctr;
        bit stopped, e_taken, e_undef, st;
        string ttag;
        e_undef = vf & (a | m[1]);
        stopped = 0;
        d = 0;
        if (vl == 0) begin
            e_taken = 0; e_vl = 0; e_ctr = ctr & 255; e_lat = 1;
        end else begin
            lim = vf ? 1 : vl;
            for (int k = 0; k < lim; k++) begin
                if (!stopped) begin
                    if (a) st = pred[k] ? !cond[k] : z;
                    else   st = pred[k] & cond[k];
                    if (st) begin stopped = 1; d = k; end
                end
            end
            e_taken = stopped ? !a : a;
            e_lat   = (stopped ? d + 1 : lim) + 1;
            e_vl    = vl;
            if (m[0] && stopped && (e_taken == t)) e_vl = i ? d + 1 : d;
            e_ctr = ctr;
            if (m[1]) e_ctr = vf ? ctr - 1 : ctr - vl;
            e_ctr = e_ctr & 255;
        end
        issue(a, z, t, i, m, vf, vl, ctr, cond, pred, lat);
        if (vl == 0)             ttag = "R10";
        else if (vf)             ttag = "R8";
        else if (pred[NV-1:0] != 4'hf) ttag = "R4";
        else                     ttag = a ? "R2" : "R3";
        chk(vl == 0 ? "R10" : (vf ? "R8" : "R5"), "latency", lat, e_lat);
        chk(ttag, "taken", taken_o, e_taken);
        chk(m[0] ? "R6" : "R1", "vl", vl_o, e_vl);
        chk(m[1] ? (vf ? "R9" : "R7") : "R1", "ctr", ctr_o, e_ctr);
        chk("R9", "undef", undef_o, e_undef);
    endtask

    initial begin
        int n, lat;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "done", done_o, 0);
        chk("R12", "taken", taken_o, 0);
        chk("R12", "vl", vl_o, 0);
        chk("R12", "ctr", ctr_o, 0);
        chk("R12", "undef", undef_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Horizontal sweep: every condition/predicate pattern per length and rule
        n = 0;
        for (int vl = 0; vl <= NV; vl++)
            for (int a = 0; a < 2; a++)
                for (int z = 0; z < 2; z++)
                    for (int c = 0; c < 16; c++)
                        for (int p = 0; p < 16; p++) begin
                            n++;
                            run_case(a[0], z[0], ((n / 5) % 2) == 1, ((n / 7) % 2) == 1,
                                     2'((n / 3) % 4), 1'b0, vl, n * 29, c, p);
                        end

        // Vertical-first sweep: upper condition bits vary and must not matter
        for (int vl = 0; vl <= NV; vl++)
            for (int a = 0; a < 2; a++)
                for (int m = 0; m < 4; m++)
                    for (int z = 0; z < 2; z++)
                        for (int c0 = 0; c0 < 2; c0++)
                            for (int p0 = 0; p0 < 2; p0++)
                                for (int t = 0; t < 2; t++)
                                    for (int i = 0; i < 2; i++) begin
                                        n++;
                                        run_case(a[0], z[0], t[0], i[0], 2'(m), 1'b1, vl,
                                                 n * 13, ((n % 8) << 1) | c0,
                                                 ((n % 5) << 1) | p0);
                                    end

        // R11: a second start during the scan is dropped
        all_i = 1'b1; zero_i = 1'b0; tot_i = 1'b0; incl_i = 1'b0;
        mode_i = 2'b10; vf_i = 1'b0; vl_i = VW'(4); ctr_i = 8'd100;
        cond_i = 4'hf; pred_i = 4'hf;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        vl_i = '0; ctr_i = 8'd3; mode_i = 2'b00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 3;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R11", "latency", lat, 5);
        chk("R11", "taken", taken_o, 1);
        chk("R11", "vl", vl_o, 4);
        chk("R11", "ctr", ctr_o, 96);
        repeat (3) @(negedge clk);
        chk("R11", "done after idle", done_o, 0);
        chk("R11", "ctr held", ctr_o, 96);
        chk("R11", "vl held", vl_o, 4);

        finish_run();
    end

endmodule